// File: doc/BRIEF.md
# Synchronous Flow-Through SRAM with Zero-Turnaround Writes

This block is a cycle-accurate, synthesizable model of a synchronous static RAM. The default is 256 words of 32 bits; setting `ADDR_W` to 16 gives 64K words. The RAM is split into four 8-bit byte lanes. Reads are flow-through: the word for an address captured on a clock edge appears on the output in the cycle that follows that edge. Write data lags its address by one clock edge. Because of this, a write and a read can follow each other on every cycle with no idle cycle between them.

A load cycle (`adv_ld` low) starts an access. It captures the address, the direction and the burst order. A continue cycle (`adv_ld` high) steps a 2-bit burst counter over the two low address bits, in linear or interleaved order. The continue cycle keeps the direction and the order that the burst started with.

A high `clk_en_n` freezes the whole pipeline for one edge. Three chip selects deselect the device. The `sleep` input parks the device, and the memory contents are kept while it is asserted. The shared data bus is split into `din`, `dout` and an output-enable flag `dout_oe`. The `rst_n` input clears only the control pipeline. It does not clear the memory.

Top module: `nbl_ft_sram`

## Requirements
- R1: On a write, lane i is stored only when `lane_wr_n[i]` was low on the address edge. Lane i is bits 8i+7..8i, so lane 0 is bits 7..0 and lane 3 is bits 31..24. The other lanes of the word keep their old contents.
- R2: A write whose four `lane_wr_n` bits are all 1 changes no part of the memory.
- R3: A selected load with `wr_n`=1 and `out_en_n`=0 makes `dout_oe`=1 in the cycle right after the capturing edge, and `dout` then shows the addressed word.
- R4: Write data on `din` is taken on the next enabled edge after the edge that captured the write address. A read of the same address loaded on that next edge returns the new data, with no idle cycle between the write and the read.
- R5: An edge with `clk_en_n`=1 is ignored. Address, direction and outputs are held, and no write occurs. A pending write completes on the next enabled edge, using the `din` value present on that edge.
- R6: A load edge with `sel1_n`=1, `sel2`=0 or `sel3_n`=1 deselects the device, and `dout_oe` is 0 after that edge. After reset, `dout_oe` is 0.
- R7: `adv_ld`=1 on an enabled edge advances the burst counter, whatever the values of the chip selects and `wr_n`. The burst keeps the direction it was loaded with.
- R8: With `order_sel`=0 on the load edge, access n of a burst (n = 0..3) uses low address bits (start + n) mod 4. The upper bits stay fixed.
- R9: With `order_sel`=1 on the load edge, access n uses low address bits start XOR n.
- R10: `dout_oe` is 0 whenever `out_en_n`=1. It is also 0 in the data cycle of a write, even when `out_en_n`=0.
- R11: While `sleep`=1, all other inputs are ignored, no write occurs, the memory is kept and `dout_oe`=0. After `sleep` falls, `dout_oe` stays 0 until a new selected read load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low reset of the control pipeline (not the memory) |
| clk_en_n | input | 1 | Active-low clock enable; high ignores the edge |
| sel1_n | input | 1 | Active-low chip select |
| sel2 | input | 1 | Active-high chip select |
| sel3_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Direction on a load: 0 write, 1 read |
| lane_wr_n | input | 4 | Active-low byte-lane write strobes, sampled with each address edge |
| adv_ld | input | 1 | 0 loads a new address, 1 advances the burst counter |
| order_sel | input | 1 | Burst order on a load: 0 linear, 1 interleaved |
| out_en_n | input | 1 | Active-low output enable |
| sleep | input | 1 | Sleep request; freezes the device while high |
| addr | input | ADDR_W | Word address captured on a load |
| din | input | 32 | Write data, one edge after its address |
| dout | output | 32 | Read data (zero when not driven) |
| dout_oe | output | 1 | High while `dout` is driven onto the shared bus |

## Verification
The hardest situation to reach is a write whose data phase is split from its address by one or more stalls. The data edge must pick up `din` from the first enabled edge, not from the stalled ones. The stimulus places a read load on that same data edge, so any error in the write shows up at once. Burst writes in one order are read back in the other order, with a different start offset. This shows the two orders match the expected address sequence, and that the counter keeps running while the chip selects are deasserted. A seeded random phase then mixes stalls, loads, continues, output-enable changes and partial lane masks over a pre-filled region. Every cycle's output is compared against an array model kept inside the bench.

// File: rtl/nbl_pkg.sv
package nbl_pkg;

  typedef enum logic [1:0] {
    CMD_HOLD  = 2'd0,  // edge ignored (clock enable high or sleeping)
    CMD_LOAD  = 2'd1,  // selected load: start a new access
    CMD_CONT  = 2'd2,  // advance the burst counter
    CMD_DESEL = 2'd3   // load while deselected
  } cmd_e;

  // Low two address bits for step n of a burst from start offset s.
  function automatic logic [1:0] burst_offset(input logic [1:0] s,
                                              input logic [1:0] n,
                                              input logic       interleave);
    logic [1:0] lin;
    lin = s + n;
    return interleave ? (s ^ n) : lin;
  endfunction

  // Device select decode from the three chip selects.
  function automatic logic chip_selected(input logic s1_n,
                                         input logic s2,
                                         input logic s3_n);
    return !s1_n && s2 && !s3_n;
  endfunction

endpackage

// File: rtl/nbl_cmd_decode.sv
module nbl_cmd_decode
  import nbl_pkg::*;
(
  input  logic clk_en_n,
  input  logic sleep,
  input  logic adv_ld,
  input  logic sel1_n,
  input  logic sel2,
  input  logic sel3_n,
  output cmd_e cmd
);

  logic edge_live;
  logic selected;

  assign edge_live = !clk_en_n && !sleep;
  assign selected  = chip_selected(sel1_n, sel2, sel3_n);

  always_comb begin
    if (!edge_live)    cmd = CMD_HOLD;
    else if (adv_ld)   cmd = CMD_CONT;
    else if (selected) cmd = CMD_LOAD;
    else               cmd = CMD_DESEL;
  end

endmodule

// File: rtl/nbl_burst_ctrl.sv
module nbl_burst_ctrl
  import nbl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_e              cmd,
  input  logic              sleep,
  input  logic              wr_n,
  input  logic              order_sel,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              cur_active,
  output logic              cur_wr,
  output logic              order_q,
  output logic [1:0]        cur_off,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [LANES-1:0]  lanes_q
);

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_active <= 1'b0;
      cur_wr     <= 1'b0;
      order_q    <= 1'b0;
      base_q     <= '0;
      cnt_q      <= '0;
      lanes_q    <= '1;
    end else if (sleep) begin
      cur_active <= 1'b0;
    end else begin
      case (cmd)
        CMD_LOAD: begin
          cur_active <= 1'b1;
          cur_wr     <= !wr_n;
          order_q    <= order_sel;
          base_q     <= addr;
          cnt_q      <= '0;
          lanes_q    <= lane_wr_n;
        end
        CMD_DESEL: begin
          cur_active <= 1'b0;
          lanes_q    <= lane_wr_n;
        end
        CMD_CONT: begin
          cnt_q   <= cnt_q + 2'd1;
          lanes_q <= lane_wr_n;
        end
        default: ;
      endcase
    end
  end

  assign cur_off  = burst_offset(base_q[1:0], cnt_q, order_q);
  assign cur_addr = {base_q[ADDR_W-1:2], cur_off};

endmodule

// File: rtl/nbl_wr_stage.sv
module nbl_wr_stage #(
  parameter int LANES = 4
) (
  input  logic             clk_en_n,
  input  logic             sleep,
  input  logic             cur_active,
  input  logic             cur_wr,
  input  logic [LANES-1:0] lanes_q,
  output logic             do_write,
  output logic [LANES-1:0] lane_we
);

  assign do_write = !clk_en_n && !sleep && cur_active && cur_wr;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_we[g] = do_write && !lanes_q[g];
  end

endmodule

// File: rtl/nbl_store.sv
module nbl_store #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic [LANES-1:0]  lane_we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  for (genvar g = 0; g < LANES; g++) begin : g_bank
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_we[g]) bank[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = bank[addr];
  end

endmodule

// File: rtl/nbl_ft_sram.sv
module nbl_ft_sram
  import nbl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              wr_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic              adv_ld,
  input  logic              order_sel,
  input  logic              out_en_n,
  input  logic              sleep,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);

  cmd_e              cmd;
  logic              cur_active;
  logic              cur_wr;
  logic              order_q;
  logic [1:0]        cur_off;
  logic [ADDR_W-1:0] cur_addr;
  logic [LANES-1:0]  lanes_q;
  logic              do_write;
  logic [LANES-1:0]  lane_we;
  logic [DATA_W-1:0] rdata;

  nbl_cmd_decode u_dec (
    .clk_en_n (clk_en_n),
    .sleep    (sleep),
    .adv_ld   (adv_ld),
    .sel1_n   (sel1_n),
    .sel2     (sel2),
    .sel3_n   (sel3_n),
    .cmd      (cmd)
  );

  nbl_burst_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd),
    .sleep      (sleep),
    .wr_n       (wr_n),
    .order_sel  (order_sel),
    .lane_wr_n  (lane_wr_n),
    .addr       (addr),
    .cur_active (cur_active),
    .cur_wr     (cur_wr),
    .order_q    (order_q),
    .cur_off    (cur_off),
    .cur_addr   (cur_addr),
    .lanes_q    (lanes_q)
  );

  nbl_wr_stage #(.LANES(LANES)) u_wr (
    .clk_en_n   (clk_en_n),
    .sleep      (sleep),
    .cur_active (cur_active),
    .cur_wr     (cur_wr),
    .lanes_q    (lanes_q),
    .do_write   (do_write),
    .lane_we    (lane_we)
  );

  nbl_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk     (clk),
    .lane_we (lane_we),
    .addr    (cur_addr),
    .wdata   (din),
    .rdata   (rdata)
  );

  assign dout_oe = cur_active && !cur_wr && !out_en_n && !sleep;
  assign dout    = dout_oe ? rdata : '0;

endmodule

// File: rtl/nbl_sram_chk.sv
module nbl_sram_chk #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en_n,
  input logic              sleep,
  input logic              adv_ld,
  input logic              sel1_n,
  input logic              sel2,
  input logic              sel3_n,
  input logic              out_en_n,
  input logic              dout_oe,
  input logic              cur_wr,
  input logic              order_q,
  input logic [1:0]        cur_off,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [LANES-1:0]  lane_we,
  input logic              do_write
);

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_n && !sleep) |=> ($stable(cur_addr) && $stable(cur_wr)));

  // R5
  stall_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |-> (lane_we == '0));

  // R6
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !sleep && !adv_ld && (sel1_n || !sel2 || sel3_n)) |=> !dout_oe);

  // R7
  cont_keeps_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !sleep && adv_ld) |=> (cur_wr == $past(cur_wr)));

  // R8
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !sleep && adv_ld && !order_q) |=> (cur_off == $past(cur_off) + 2'd1));

  // R10
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> (!out_en_n && !cur_wr));

  // R11
  sleep_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (!dout_oe && !do_write && lane_we == '0));

  // R1
  lane_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we != '0) |-> do_write);

endmodule

bind nbl_ft_sram nbl_sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clk_en_n (clk_en_n),
  .sleep    (sleep),
  .adv_ld   (adv_ld),
  .sel1_n   (sel1_n),
  .sel2     (sel2),
  .sel3_n   (sel3_n),
  .out_en_n (out_en_n),
  .dout_oe  (dout_oe),
  .cur_wr   (cur_wr),
  .order_q  (order_q),
  .cur_off  (cur_off),
  .cur_addr (cur_addr),
  .lane_we  (lane_we),
  .do_write (do_write)
);

// File: tb/tb_nbl_ft_sram.sv
module tb_nbl_ft_sram;

  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clk_en_n = 1'b0, sel1_n = 1'b1, sel2 = 1'b1, sel3_n = 1'b0;
  logic          wr_n = 1'b1, adv_ld = 1'b0, order_sel = 1'b0, out_en_n = 1'b0, sleep = 1'b0;
  logic [3:0]    lane_wr_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [31:0]   din = '0;
  logic [31:0]   dout;
  logic          dout_oe;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  nbl_ft_sram #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel1_n(sel1_n), .sel2(sel2),
    .sel3_n(sel3_n), .wr_n(wr_n), .lane_wr_n(lane_wr_n), .adv_ld(adv_ld),
    .order_sel(order_sel), .out_en_n(out_en_n), .sleep(sleep), .addr(addr),
    .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  // ---------------- reference model ----------------
  logic [31:0]   m_mem [1 << AW];
  bit            m_act = 0, m_wr = 0, m_ord = 0;
  logic [AW-1:0] m_base = '0;
  int            m_step = 0;
  logic [3:0]    m_bw = 4'hF;

  typedef struct {
    bit          oe;
    logic [31:0] data;
    string       tag;
  } exp_t;
  exp_t sb[$];

  function automatic logic [AW-1:0] model_addr();
    int lo;
    int s;
    s = int'(m_base[1:0]);
    // linear: add with wrap; interleaved: flip bits of the start by the step
    if (m_ord) lo = (((s >> 1) ^ (m_step >> 1)) & 1) * 2 + ((s ^ m_step) & 1);
    else       lo = (s + m_step) % 4;
    return {m_base[AW-1:2], 2'(lo)};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, model update, expectation push
  task automatic drv(input bit ce_n, input bit adv, input bit s1n, input bit s2,
                     input bit s3n, input bit wrn, input logic [3:0] bw,
                     input bit ord, input bit oen, input bit slp,
                     input logic [AW-1:0] a, input logic [31:0] d, input string tag);
    exp_t e;
    @(negedge clk);
    clk_en_n = ce_n; adv_ld = adv; sel1_n = s1n; sel2 = s2; sel3_n = s3n;
    wr_n = wrn; lane_wr_n = bw; order_sel = ord; out_en_n = oen; sleep = slp;
    addr = a; din = d;
    if (!ce_n && !slp) begin
      if (m_act && m_wr) begin
        logic [AW-1:0] wa;
        wa = model_addr();
        for (int i = 0; i < 4; i++)
          if (!m_bw[i]) m_mem[wa][8*i +: 8] = d[8*i +: 8];
      end
      if (!adv) begin
        if (!s1n && s2 && !s3n) begin
          m_act = 1; m_wr = !wrn; m_base = a; m_step = 0; m_ord = ord;
        end else begin
          m_act = 0;
        end
      end else begin
        m_step = (m_step + 1) % 4;
      end
      m_bw = bw;
    end
    if (slp) m_act = 0;
    e.oe = m_act && !m_wr && !oen && !slp;
    e.data = e.oe ? m_mem[model_addr()] : 32'h0;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic load_wr(input logic [AW-1:0] a, input logic [3:0] bw, input bit ord,
                         input logic [31:0] d, input string tag);
    drv(0, 0, 0, 1, 0, 0, bw, ord, 0, 0, a, d, tag);
  endtask
  task automatic load_rd(input logic [AW-1:0] a, input bit ord, input logic [31:0] d,
                         input string tag);
    drv(0, 0, 0, 1, 0, 1, 4'hF, ord, 0, 0, a, d, tag);
  endtask
  task automatic cont(input logic [3:0] bw, input logic [31:0] d, input string tag);
    drv(0, 1, 0, 1, 0, 1, bw, 0, 0, 0, '0, d, tag);
  endtask
  task automatic desel(input logic [31:0] d, input string tag);
    drv(0, 0, 1, 1, 0, 1, 4'hF, 0, 0, 0, '0, d, tag);
  endtask
  task automatic stall(input logic [31:0] d, input string tag);
    drv(1, 0, 0, 1, 0, 0, 4'h0, 1, 0, 0, 8'hEE, d, tag);
  endtask

  // monitor: compare one expectation per clock, just after the edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(dout_oe == e.oe, {e.tag, " oe"}, 32'(dout_oe), 32'(e.oe));
      if (e.oe) check(dout == e.data, {e.tag, " data"}, dout, e.data);
    end
  end

  function automatic logic [31:0] pat(input int i);
    return 32'hA5000000 ^ (32'(i) * 32'h01030507);
  endfunction

  initial begin : watchdog
    #(200000 * 4);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] lf;
    for (int i = 0; i < (1 << AW); i++) m_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R6)
    check(dout_oe == 1'b0, "R6 reset", 32'(dout_oe), 32'h0);

    // R4 / R3: write then immediate read of the same word
    load_wr(8'h80, 4'h0, 0, 32'h0, "R4");
    load_rd(8'h80, 0, 32'h11223344, "R3 r4_back_to_back");
    load_wr(8'h81, 4'h0, 0, 32'h0, "R4");
    load_wr(8'h82, 4'h0, 0, 32'h55667788, "R4");
    load_rd(8'h81, 0, 32'h99AABBCC, "R3");
    load_rd(8'h82, 0, 32'h0, "R3");

    // R1: partial lanes 0 and 2 on 0x80
    load_wr(8'h80, 4'b1010, 0, 32'h0, "R1");
    load_rd(8'h80, 0, 32'hDDEEFF00, "R1 partial");
    // R2: no lanes on 0x81
    load_wr(8'h81, 4'hF, 0, 32'h0, "R2");
    load_rd(8'h81, 0, 32'hFFFFFFFF, "R2 none");

    // R5: stall between address and data phase
    load_wr(8'h90, 4'h0, 0, 32'h0, "R5");
    stall(32'hDEAD0001, "R5 stall");
    stall(32'hDEAD0002, "R5 stall");
    load_rd(8'h90, 0, 32'hCAFEF00D, "R5 data after stall");
    stall(32'h0, "R5 read hold");
    stall(32'h0, "R5 read hold");
    desel(32'h0, "R6");

    // R8: linear write burst from offset 2, R9: read back interleaved from 3
    load_wr(8'hA2, 4'h0, 0, 32'h0, "R8");
    cont(4'h0, pat(1), "R8");
    cont(4'h0, pat(2), "R8");
    cont(4'h0, pat(3), "R8");
    load_rd(8'hA3, 1, pat(4), "R9");
    cont(4'hF, 32'h0, "R9");
    cont(4'hF, 32'h0, "R9");
    cont(4'hF, 32'h0, "R9");
    // interleaved write from offset 1, read back linear from 0
    load_wr(8'hB1, 4'h0, 1, 32'h0, "R9");
    cont(4'h0, pat(11), "R9");
    cont(4'h0, pat(12), "R9");
    cont(4'h0, pat(13), "R9");
    load_rd(8'hB0, 0, pat(14), "R8");
    // R7: continue with chip deselected and wr_n low keeps reading
    drv(0, 1, 1, 0, 1, 0, 4'h0, 0, 0, 0, '0, 32'h0, "R7");
    drv(0, 1, 0, 1, 1, 0, 4'h0, 1, 0, 0, '0, 32'h0, "R7");
    cont(4'hF, 32'h0, "R7 wrap");

    // R6: each chip select alone deselects
    load_rd(8'h80, 0, 32'h0, "R3");
    drv(0, 0, 1, 1, 0, 1, 4'hF, 0, 0, 0, 8'h80, 32'h0, "R6 sel1");
    load_rd(8'h80, 0, 32'h0, "R3");
    drv(0, 0, 0, 0, 0, 1, 4'hF, 0, 0, 0, 8'h80, 32'h0, "R6 sel2");
    load_rd(8'h80, 0, 32'h0, "R3");
    drv(0, 0, 0, 1, 1, 1, 4'hF, 0, 0, 0, 8'h80, 32'h0, "R6 sel3");

    // R10: output enable high on a read; data phase of a write with oe low
    drv(0, 0, 0, 1, 0, 1, 4'hF, 0, 1, 0, 8'h80, 32'h0, "R10 oe high");
    load_wr(8'h84, 4'h0, 0, 32'h0, "R10");
    drv(0, 1, 0, 1, 0, 1, 4'h0, 0, 0, 0, '0, 32'h0BADBEEF, "R10 write phase");
    desel(32'h12345678, "R10");
    load_rd(8'h84, 0, 32'h0, "R10");
    load_rd(8'h85, 0, 32'h0, "R10");

    // R11: sleep from deselect, write-looking inputs ignored
    desel(32'h0, "R11");
    drv(0, 0, 0, 1, 0, 0, 4'h0, 0, 0, 1, 8'h80, 32'hFFFFFFFF, "R11 sleep");
    drv(0, 1, 0, 1, 0, 0, 4'h0, 0, 0, 1, 8'h80, 32'hFFFFFFFF, "R11 sleep");
    drv(0, 0, 0, 1, 0, 1, 4'hF, 0, 0, 1, 8'h80, 32'hFFFFFFFF, "R11 sleep read");
    cont(4'hF, 32'h0, "R11 exit");
    cont(4'hF, 32'h0, "R11 exit");
    load_rd(8'h80, 0, 32'h0, "R11 kept");

    // fill 0x00..0x0F with linear bursts
    for (int i = 0; i < 16; i++) begin
      if (i % 4 == 0) load_wr(8'(i), 4'h0, 0, (i == 0) ? 32'h0 : pat(100 + i - 1), "R8 fill");
      else cont(4'h0, pat(100 + i - 1), "R8 fill");
    end
    desel(pat(115), "R6");

    // seeded random mix over the filled region
    lf = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      bit ce_n, adv, s1n, wrn, ord, oen;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      ce_n = (lf[2:0] == 3'd0);
      adv  = lf[3] & lf[4];
      s1n  = (lf[7:5] == 3'd7);
      wrn  = lf[8];
      ord  = lf[9];
      oen  = (lf[12:10] == 3'd0);
      drv(ce_n, adv, s1n, 1, 0, wrn, lf[14:11], ord, oen, 0, 8'(lf[15:12]),
          {lf, ~lf}, "R4 mix");
    end
    desel(32'h0, "R6");
    repeat (3) @(negedge clk);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule